// File: doc/BRIEF.md
# Multiplex Row Bank Selector

This block decides which of the four rows of each display RAM address is copied into the segment display register at every step of the backplane multiplex sequence. A phase counter advances on a multiplex tick. Its wrap length follows the selected drive mode: one step for static drive, two for 1:2, three for 1:3 and four for 1:4. On every tick the block raises a one-cycle load strobe. Together with the strobe it presents the 2-bit row index and the phase that the index belongs to.

In the two lowest multiplex modes the display RAM holds two pictures. A bank-select bit moves the displayed rows to the upper half of the RAM row space, so software can prepare one picture while the other is shown. A bank change is applied only at the start of a multiplex frame, so a frame never mixes rows from two banks. A change of drive mode restarts the sequence at phase 0.

Top module: `mux_row_selector`

## Requirements
- R1: With driveMode = 2'b11 (1:4), successive loads carry phase 0,1,2,3,0,... and rowIdx equal to the phase, whatever the bank-select bit is.
- R2: With driveMode = 2'b10 (1:3), successive loads carry phase 0,1,2,0,... and rowIdx equal to the phase, whatever the bank-select bit is.
- R3: With driveMode = 2'b01 (1:2), successive loads carry phase 0,1,0,... The rowIdx is the phase when the frame's bank is 0, and the phase plus 2 when the frame's bank is 1.
- R4: With driveMode = 2'b00 (static), every load carries phase 0. The rowIdx is 0 when the frame's bank is 0 and 2 when it is 1.
- R5: loadStb is high in the cycle after each cycle in which tick is high, and low otherwise. rowIdx and phase change only in a cycle where loadStb is high, and hold their values between loads.
- R6: If driveMode differs from its value in the previous cycle, the next load carries phase 0. This also holds when the tick arrives in the same cycle as the change.
- R7: A frame's bank is the value of bankSel sampled with the tick that issues phase 0. Changes of bankSel at other ticks do not affect rowIdx until the next phase-0 load.
- R8: After reset, loadStb, rowIdx and phase are 0, and the first load carries phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Multiplex step request, one cycle per step |
| driveMode | input | 2 | 00 static, 01 1:2, 10 1:3, 11 1:4 |
| bankSel | input | 1 | Upper RAM bank request for static and 1:2 modes |
| rowIdx | output | 2 | RAM row to copy into the display register |
| loadStb | output | 1 | One-cycle display register load strobe |
| phase | output | 2 | Multiplex phase of the current load |

## Verification
The bound checker enforces, on every cycle, the properties that need no history beyond a cycle or two. These are the strobe timing and the holding of the outputs between loads (R5). They also cover the mapping from phase to row in each mode (R1 to R4), the range of the phase, and the restart at phase 0 after a mode change (R6). The exact order of phases across a whole frame cannot be checked that way. Neither can the rule that a bank request waits for the next frame (R7), because both depend on history that spans a whole frame. The bench covers them with a behavioural model compared on every clock, during runs with mid-frame bank toggles, mode switches that coincide with ticks, back-to-back ticks and random stimulus.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam int ROW_W   = 2;
  localparam int PHASE_W = 2;
  localparam int MODE_W  = 2;
  localparam int N_MODES = 1 << MODE_W;
  localparam logic [ROW_W-1:0] BANK_OFS = ROW_W'(2);

  typedef enum logic [MODE_W-1:0] {
    MODE_STATIC = 2'b00,
    MODE_MUX2   = 2'b01,
    MODE_MUX3   = 2'b10,
    MODE_MUX4   = 2'b11
  } drive_mode_e;

  typedef struct packed {
    logic                issue;
    logic [PHASE_W-1:0]  phase;
    logic                useBank;
    drive_mode_e         mode;
  } ctrl_s;

  // last phase index before wrap for each drive mode
  function automatic logic [PHASE_W-1:0] lastPhase(input drive_mode_e m);
    case (m)
      MODE_STATIC: lastPhase = PHASE_W'(0);
      MODE_MUX2:   lastPhase = PHASE_W'(1);
      MODE_MUX3:   lastPhase = PHASE_W'(2);
      default:     lastPhase = PHASE_W'(3);
    endcase
  endfunction

  // whether the drive mode supports a second RAM bank
  function automatic logic bankCapable(input drive_mode_e m);
    bankCapable = (m == MODE_STATIC) || (m == MODE_MUX2);
  endfunction

endpackage

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  drive_mode_e driveMode,
  input  logic        bankSel,
  output ctrl_s       ctrl
);

  drive_mode_e         modeQ;
  logic [PHASE_W-1:0]  phaseCnt;
  logic                bankQ;

  logic                modeChg;
  logic [PHASE_W-1:0]  curPhase;
  logic                frameStart;
  logic                effBank;
  logic [PHASE_W-1:0]  nextPhase;

  always_comb begin
    modeChg    = (driveMode != modeQ);
    curPhase   = modeChg ? '0 : phaseCnt;
    frameStart = (curPhase == '0);
    effBank    = frameStart ? bankSel : bankQ;
    if (curPhase >= lastPhase(driveMode))
      nextPhase = '0;
    else
      nextPhase = curPhase + PHASE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_STATIC;
      phaseCnt <= '0;
      bankQ    <= 1'b0;
    end else begin
      modeQ <= driveMode;
      if (tick) begin
        phaseCnt <= nextPhase;
        if (frameStart) bankQ <= bankSel;
      end else begin
        phaseCnt <= curPhase;
      end
    end
  end

  always_comb begin
    ctrl.issue   = tick;
    ctrl.phase   = curPhase;
    ctrl.useBank = effBank;
    ctrl.mode    = driveMode;
  end

endmodule

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_s               ctrl,
  output logic [ROW_W-1:0]    rowIdx,
  output logic                loadStb,
  output logic [PHASE_W-1:0]  phase
);

  logic [ROW_W-1:0] rowCand [N_MODES];
  logic [ROW_W-1:0] rowSel;

  // one candidate row per drive mode
  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    localparam drive_mode_e MODE = drive_mode_e'(m);
    always_comb begin
      if (bankCapable(MODE) && ctrl.useBank)
        rowCand[m] = ROW_W'(ctrl.phase) + BANK_OFS;
      else
        rowCand[m] = ROW_W'(ctrl.phase);
    end
  end

  always_comb rowSel = rowCand[ctrl.mode];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowIdx  <= '0;
      phase   <= '0;
      loadStb <= 1'b0;
    end else begin
      loadStb <= ctrl.issue;
      if (ctrl.issue) begin
        rowIdx <= rowSel;
        phase  <= ctrl.phase;
      end
    end
  end

endmodule

// File: rtl/mux_row_selector.sv
module mux_row_selector
  import mrs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [MODE_W-1:0]   driveMode,
  input  logic                bankSel,
  output logic [ROW_W-1:0]    rowIdx,
  output logic                loadStb,
  output logic [PHASE_W-1:0]  phase
);

  ctrl_s ctrlBus;

  mrs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .driveMode (drive_mode_e'(driveMode)),
    .bankSel   (bankSel),
    .ctrl      (ctrlBus)
  );

  mrs_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlBus),
    .rowIdx  (rowIdx),
    .loadStb (loadStb),
    .phase   (phase)
  );

endmodule

// File: rtl/mux_row_selector_chk.sv
module mux_row_selector_chk
  import mrs_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic [MODE_W-1:0]  driveMode,
  input logic [ROW_W-1:0]   rowIdx,
  input logic               loadStb,
  input logic [PHASE_W-1:0] phase
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic live1, live2;
  assign live1 = (sinceRst >= 2'd1);
  assign live2 = (sinceRst >= 2'd2);

  AST_STB_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    live1 |-> (loadStb == $past(tick)));  // R5

  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (live1 && !loadStb) |-> ($stable(rowIdx) && $stable(phase)));  // R5

  AST_MUX4_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (live1 && loadStb && $past(driveMode) == 2'b11) |-> (rowIdx == phase));  // R1

  AST_MUX3_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (live1 && loadStb && $past(driveMode) == 2'b10) |-> (rowIdx == phase && phase != 2'd3));  // R2

  AST_MUX2_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (live1 && loadStb && $past(driveMode) == 2'b01) |-> (rowIdx[0] == phase[0] && phase[1] == 1'b0));  // R3

  AST_STATIC_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (live1 && loadStb && $past(driveMode) == 2'b00) |-> (phase == 2'd0 && rowIdx[0] == 1'b0));  // R4

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (live2 && loadStb && $past(driveMode) != $past(driveMode, 2)) |-> (phase == 2'd0));  // R6

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd1 && loadStb) |-> (phase == 2'd0));  // R8

endmodule

bind mux_row_selector mux_row_selector_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .driveMode (driveMode),
  .rowIdx    (rowIdx),
  .loadStb   (loadStb),
  .phase     (phase)
);

// File: tb/mux_row_selector_tb.sv
module mux_row_selector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] driveMode = 2'b00;
  logic       bankSel = 1'b0;
  logic [1:0] rowIdx;
  logic       loadStb;
  logic [1:0] phase;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string curReq = "R8";
  bit done = 0;

  // reference model state
  int mCnt = 0, mMode = 0, mBank = 0;
  int eRow = 0, ePh = 0, eStb = 0;

  mux_row_selector u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .driveMode(driveMode),
    .bankSel(bankSel), .rowIdx(rowIdx), .loadStb(loadStb), .phase(phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int stepsOf(int m);
    return m + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mMode = 0; mBank = 0; eRow = 0; ePh = 0; eStb = 0;
    end else begin
      int p;
      int b;
      p = (int'(driveMode) != mMode) ? 0 : mCnt;
      eStb = int'(tick);
      if (tick) begin
        b = (p == 0) ? int'(bankSel) : mBank;
        mBank = b;
        ePh = p;
        case (int'(driveMode))
          0: eRow = b ? 2 : 0;
          1: eRow = p + (b ? 2 : 0);
          default: eRow = p;
        endcase
        mCnt = (p + 1) % stepsOf(int'(driveMode));
      end else begin
        mCnt = p;
      end
      mMode = int'(driveMode);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(loadStb) != eStb || int'(rowIdx) != eRow || int'(phase) != ePh) begin
        errors++;
        $display("FAIL %s: stb/row/phase actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 curReq, loadStb, rowIdx, phase, eStb, eRow, ePh);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      idle(gap);
    end
  endtask

  initial begin
    @(negedge clk);
    idle(3);
    rstN = 1'b1;
    curReq = "R8";           // reset state and first load
    idle(2);
    pulses(2, 1);

    curReq = "R1";           // 1:4 sequence, bank ignored
    driveMode = 2'b11; bankSel = 1'b1;
    idle(1);
    pulses(9, 2);
    bankSel = 1'b0;

    curReq = "R2";           // 1:3 sequence
    driveMode = 2'b10;
    pulses(8, 1);

    curReq = "R3";           // 1:2 both banks
    driveMode = 2'b01;
    pulses(4, 0);
    bankSel = 1'b1;
    pulses(4, 1);

    curReq = "R7";           // bank change mid frame waits
    pulses(1, 0);            // phase 0 bank 1
    bankSel = 1'b0;
    pulses(1, 0);            // phase 1 keeps bank 1
    pulses(2, 0);            // new frame, bank 0

    curReq = "R4";           // static with bank
    driveMode = 2'b00;
    pulses(3, 0);
    bankSel = 1'b1;
    pulses(3, 1);
    bankSel = 1'b0;
    pulses(2, 0);

    curReq = "R6";           // mode change with coincident tick
    driveMode = 2'b11;
    pulses(2, 0);
    driveMode = 2'b10;       // changes in the same cycle as the tick
    pulses(3, 0);
    driveMode = 2'b11;
    idle(1);
    pulses(2, 1);
    driveMode = 2'b01;
    idle(3);
    pulses(3, 0);

    curReq = "R5";           // random stimulus, strobe and hold
    for (int i = 0; i < 400; i++) begin
      tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 15) == 0) driveMode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) bankSel = ~bankSel;
      @(negedge clk);
    end
    tick = 1'b0;

    curReq = "R8";           // reset mid-run
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    driveMode = 2'b11;
    idle(1);
    pulses(3, 0);
    idle(2);
    finishRun();
  end

endmodule